// File: doc/BRIEF.md
# Clock-recovery training-source switchover controller

This block chooses what trains the oscillator of a clock-recovery PLL. It can train it from the local reference clock or from the incoming serial data. The controller counts edges of a divided recovered clock against a fixed window of reference-clock cycles and turns the difference into a frequency error in counts. It compares that error with one of four ppm limits and combines the result with a digital phase-match indication from the phase detector. When the oscillator is close enough in both frequency and phase, the controller moves training over to the data.

Two override inputs can take the choice away from the automatic logic. The data-force input wins over the reference-force input. With both inputs low, the automatic logic runs, so a design that ties them off gets automatic switching. The recovered-clock count is a free-running counter in its own clock domain. A toggle request/acknowledge handshake samples it into the reference domain, and the reference side takes the difference between successive samples.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: A synchronous active-high `rst` leaves `lock_to_data` and `freq_locked` at 0 (reference training) on the clock edge after it is sampled.
- R2: With `force_data` at 1, `lock_to_data` is 1 from the next `clk` edge onward, whatever `force_ref`, the phase-match input or the frequency error does.
- R3: With `force_data` at 0 and `force_ref` at 1, `lock_to_data` is 0 from the next `clk` edge onward, even when the frequency and phase conditions would allow data training.
- R4: With both override inputs at 0, the automatic logic moves from reference training to data training on its own once its conditions hold.
- R5: Automatic entry into data training needs `GOOD_WINDOWS` (default 2) consecutive good windows. A single good window leaves `lock_to_data` at 0.
- R6: A window counts as good only if `phase_match` is 1 when the window result is taken. With `phase_match` held at 0, `lock_to_data` never rises in automatic mode.
- R7: `thr_sel` selects the frequency limit: 0 = 125 ppm, 1 = 250 ppm, 2 = 500 ppm, 3 = 1000 ppm. The limit in counts is floor(ppm x 2^WIN_LOG2 / 10^6). A window is within the limit when |recovered count - 2^WIN_LOG2| <= limit.
- R8: In automatic mode while in data training, a window whose frequency error exceeds the selected limit returns the controller to reference training.
- R9: `freq_locked` is 1 exactly while data training is selected, and so always equals `lock_to_data`.
- R10: Each evaluated window spans 2^WIN_LOG2 reference cycles. Every change of training mode restarts the window, and the first sample after the restart serves only as a baseline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all control logic runs on it |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| rec_clk | input | 1 | Divided recovered clock from the PLL |
| thr_sel | input | 2 | Frequency limit select (125/250/500/1000 ppm) |
| phase_match | input | 1 | 1 when reference and PLL output phases agree |
| force_data | input | 1 | Override: force data training |
| force_ref | input | 1 | Override: force reference training (when force_data is 0) |
| lock_to_data | output | 1 | 1 selects data training, 0 reference training |
| freq_locked | output | 1 | Status: controller is in data training |

## Verification
A wrong mode register or a wrong override decode shows at `lock_to_data` one reference edge after the override inputs change, so the override checks sample on the next falling edge. Faults in the window counter, the handshake or the error arithmetic only show at window boundaries: a lock that comes one window early, a lock that never comes, or a fallback that never happens. The automatic checks therefore sample at half-window offsets between results, where the expected mode is unambiguous. The frequency offsets in the stimulus keep the error at least one count away from each limit, so that one count of sampling jitter cannot flip a result.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

   typedef enum logic {
      TRAIN_REF  = 1'b0,
      TRAIN_DATA = 1'b1
   } train_e;

   typedef enum logic [1:0] {
      OVR_AUTO = 2'd0,
      OVR_REF  = 2'd1,
      OVR_DATA = 2'd2
   } ovr_e;

   // data force wins over reference force
   function automatic ovr_e decode_ovr(input logic fd, input logic fr);
      if (fd)      return OVR_DATA;
      else if (fr) return OVR_REF;
      else         return OVR_AUTO;
   endfunction

   // ppm limit converted to counts over a 2^log2 window
   function automatic longint ppm_to_counts(input longint ppm, input int log2);
      return (ppm << log2) / 64'sd1000000;
   endfunction

endpackage

// File: rtl/cdr_sync_bit.sv
module cdr_sync_bit #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cdr_sync_bit: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cdr_rec_snap.sv
module cdr_rec_snap #(
   parameter int CW     = 22,
   parameter int STAGES = 2
) (
   input  logic          rec_clk,
   input  logic          rst,
   input  logic          req_tgl,
   output logic          ack_tgl,
   output logic [CW-1:0] snap
);

   logic [1:0]    rrst_q;
   logic          rrst;
   logic          req_s;
   logic          req_seen;
   logic [CW-1:0] edge_cnt;

   // reset carried into the recovered domain
   always_ff @(posedge rec_clk) rrst_q <= {rrst_q[0], rst};
   assign rrst = rrst_q[1];

   cdr_sync_bit #(.STAGES(STAGES)) u_req_sync (
      .clk (rec_clk),
      .rst (rrst),
      .d   (req_tgl),
      .q   (req_s)
   );

   always_ff @(posedge rec_clk) begin
      if (rrst) begin
         edge_cnt <= '0;
         req_seen <= 1'b0;
         ack_tgl  <= 1'b0;
         snap     <= '0;
      end else begin
         edge_cnt <= edge_cnt + 1'b1;
         if (req_s != req_seen) begin
            req_seen <= req_s;
            snap     <= edge_cnt;
            ack_tgl  <= ~ack_tgl;
         end
      end
   end

endmodule

// File: rtl/cdr_freq_meter.sv
module cdr_freq_meter #(
   parameter int WIN_LOG2 = 20,
   parameter int CW       = WIN_LOG2 + 2,
   parameter int STAGES   = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rec_clk,
   input  logic          restart,
   output logic          res_valid,
   output logic [CW-1:0] err
);

   localparam logic [CW-1:0] WIN = CW'(1) << WIN_LOG2;

   logic [WIN_LOG2-1:0] win_cnt;
   logic                busy, pend, cmp_next, req_tgl, ack_seen;
   logic                ack_tgl, ack_s;
   logic [CW-1:0]       snap, prev, delta, abs_err;
   logic                win_end, start_req, launch;

   cdr_rec_snap #(.CW(CW), .STAGES(STAGES)) u_snap (
      .rec_clk (rec_clk),
      .rst     (rst),
      .req_tgl (req_tgl),
      .ack_tgl (ack_tgl),
      .snap    (snap)
   );

   cdr_sync_bit #(.STAGES(STAGES)) u_ack_sync (
      .clk (clk),
      .rst (rst),
      .d   (ack_tgl),
      .q   (ack_s)
   );

   always_comb begin
      win_end   = &win_cnt;
      start_req = pend | restart;
      launch    = !busy && (start_req || win_end);
      delta     = snap - prev;
      abs_err   = (delta >= WIN) ? (delta - WIN) : (WIN - delta);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         win_cnt   <= '0;
         busy      <= 1'b0;
         pend      <= 1'b1;
         cmp_next  <= 1'b0;
         req_tgl   <= 1'b0;
         ack_seen  <= 1'b0;
         prev      <= '0;
         res_valid <= 1'b0;
         err       <= '0;
      end else begin
         res_valid <= 1'b0;
         if (launch) begin
            req_tgl  <= ~req_tgl;
            busy     <= 1'b1;
            win_cnt  <= '0;
            cmp_next <= !start_req;
            pend     <= 1'b0;
         end else begin
            pend <= start_req;
            if (!win_end) win_cnt <= win_cnt + 1'b1;
         end
         if (ack_s != ack_seen) begin
            ack_seen <= ack_s;
            busy     <= 1'b0;
            prev     <= snap;
            if (cmp_next) begin
               res_valid <= 1'b1;
               err       <= abs_err;
            end
         end
      end
   end

   // R10
   req_launch_chk: assert property (@(posedge clk) disable iff (rst)
      (req_tgl != $past(req_tgl)) |-> !$past(busy));

   // R10
   result_idle_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> !busy);

endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl
   import cdr_lock_pkg::*;
#(
   parameter int WIN_LOG2     = 20,
   parameter int SYNC_STAGES  = 2,
   parameter int GOOD_WINDOWS = 2,
   parameter int PPM_SEL0     = 125,
   parameter int PPM_SEL1     = 250,
   parameter int PPM_SEL2     = 500,
   parameter int PPM_SEL3     = 1000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rec_clk,
   input  logic [1:0] thr_sel,
   input  logic       phase_match,
   input  logic       force_data,
   input  logic       force_ref,
   output logic       lock_to_data,
   output logic       freq_locked
);

   localparam int CW  = WIN_LOG2 + 2;
   localparam int GCW = $clog2(GOOD_WINDOWS + 1);
   localparam logic [CW-1:0] THR0 = CW'(ppm_to_counts(longint'(PPM_SEL0), WIN_LOG2));
   localparam logic [CW-1:0] THR1 = CW'(ppm_to_counts(longint'(PPM_SEL1), WIN_LOG2));
   localparam logic [CW-1:0] THR2 = CW'(ppm_to_counts(longint'(PPM_SEL2), WIN_LOG2));
   localparam logic [CW-1:0] THR3 = CW'(ppm_to_counts(longint'(PPM_SEL3), WIN_LOG2));
   localparam logic [GCW-1:0] GOOD_LAST = GCW'(GOOD_WINDOWS - 1);

   if (WIN_LOG2 < 8 || WIN_LOG2 > 30) begin : g_bad_win
      $error("cdr_lock_ctrl: WIN_LOG2 out of range 8..30");
   end
   if (GOOD_WINDOWS < 1) begin : g_bad_good
      $error("cdr_lock_ctrl: GOOD_WINDOWS must be at least 1");
   end

   train_e          mode_q, mode_nxt, auto_nxt;
   ovr_e            ovr;
   logic [GCW-1:0]  good_q, good_nxt;
   logic [CW-1:0]   thr_cur, err;
   logic            res_valid, freq_ok, restart;
   logic            lock_q, flag_q;

   cdr_freq_meter #(.WIN_LOG2(WIN_LOG2), .CW(CW), .STAGES(SYNC_STAGES)) u_meter (
      .clk       (clk),
      .rst       (rst),
      .rec_clk   (rec_clk),
      .restart   (restart),
      .res_valid (res_valid),
      .err       (err)
   );

   always_comb begin
      case (thr_sel)
         2'd0:    thr_cur = THR0;
         2'd1:    thr_cur = THR1;
         2'd2:    thr_cur = THR2;
         default: thr_cur = THR3;
      endcase
      freq_ok  = (err <= thr_cur);
      ovr      = decode_ovr(force_data, force_ref);
      auto_nxt = mode_q;
      good_nxt = good_q;
      if (res_valid) begin
         if (freq_ok && phase_match) begin
            if (mode_q == TRAIN_REF) begin
               if (good_q >= GOOD_LAST) begin
                  auto_nxt = TRAIN_DATA;
                  good_nxt = '0;
               end else begin
                  good_nxt = good_q + 1'b1;
               end
            end
         end else begin
            good_nxt = '0;
            if (!freq_ok && mode_q == TRAIN_DATA) auto_nxt = TRAIN_REF;
         end
      end
      case (ovr)
         OVR_DATA: begin mode_nxt = TRAIN_DATA; good_nxt = '0; end
         OVR_REF:  begin mode_nxt = TRAIN_REF;  good_nxt = '0; end
         default:  mode_nxt = auto_nxt;
      endcase
      restart = (mode_nxt != mode_q);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= TRAIN_REF;
         good_q <= '0;
         lock_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         mode_q <= mode_nxt;
         good_q <= good_nxt;
         lock_q <= (mode_nxt == TRAIN_DATA);
         flag_q <= (mode_nxt == TRAIN_DATA);
      end
   end

   assign lock_to_data = lock_q;
   assign freq_locked  = flag_q;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!lock_to_data && !freq_locked));

   // R2
   force_data_chk: assert property (@(posedge clk) disable iff (rst)
      force_data |=> lock_to_data);

   // R3
   force_ref_chk: assert property (@(posedge clk) disable iff (rst)
      (force_ref && !force_data) |=> !lock_to_data);

   // R6
   phase_gate_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(lock_to_data) && !$past(force_data)) |-> $past(phase_match));

   // R8
   fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(lock_to_data) && !$past(force_ref)) |-> $past(res_valid));

endmodule

// File: tb/cdr_lock_ctrl_bench.sv
`timescale 1ns/1ps
module cdr_lock_ctrl_bench;

   localparam int WL = 12;
   localparam int W  = 1 << WL;

   logic       clk = 1'b0;
   logic       rec_clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] thr_sel = 2'd3;
   logic       phase_match = 1'b1;
   logic       force_data = 1'b0;
   logic       force_ref = 1'b0;
   logic       lock_to_data, freq_locked;

   int n_checks = 0;
   int n_fail   = 0;
   int skip_k   = 0;
   bit done     = 1'b0;

   cdr_lock_ctrl #(.WIN_LOG2(WL)) u_cdr_lock_ctrl (
      .clk          (clk),
      .rst          (rst),
      .rec_clk      (rec_clk),
      .thr_sel      (thr_sel),
      .phase_match  (phase_match),
      .force_data   (force_data),
      .force_ref    (force_ref),
      .lock_to_data (lock_to_data),
      .freq_locked  (freq_locked)
   );

   always #5 clk = ~clk;

   // recovered clock: nominal 10 ns, one period dropped every skip_k periods
   initial begin
      int n = 0;
      #3;
      forever begin
         #5 rec_clk = 1'b1;
         #5 rec_clk = 1'b0;
         n++;
         if (skip_k != 0 && (n % skip_k) == 0) #10;
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input int k, input logic [1:0] sel, input logic ph);
      @(negedge clk);
      rst = 1'b1; skip_k = k; thr_sel = sel; phase_match = ph;
      force_data = 1'b0; force_ref = 1'b0;
      wait_cyc(6);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset(0, 2'd3, 1'b1);
      check("R1 lock after reset", lock_to_data, 1'b0);
      check("R1 flag after reset", freq_locked, 1'b0);
   endtask

   task automatic t_auto_and_fallback();
      do_reset(0, 2'd3, 1'b1);
      wait_cyc(W + W/2);
      check("R5 one good window only", lock_to_data, 1'b0);
      wait_cyc(W);
      check("R4 auto lock to data", lock_to_data, 1'b1);
      check("R9 flag while data", freq_locked, 1'b1);
      skip_k = 100;
      wait_cyc(W/4);
      check("R10 fresh window after change", lock_to_data, 1'b1);
      wait_cyc(W + W/4);
      check("R8 fallback on large error", lock_to_data, 1'b0);
      check("R9 flag cleared", freq_locked, 1'b0);
   endtask

   task automatic t_phase();
      do_reset(0, 2'd3, 1'b0);
      wait_cyc(3*W + W/2);
      check("R6 no lock without phase match", lock_to_data, 1'b0);
      phase_match = 1'b1;
      wait_cyc(2*W + W/4);
      check("R6 lock once phase matches", lock_to_data, 1'b1);
   endtask

   task automatic t_threshold();
      do_reset(1365, 2'd1, 1'b1);
      wait_cyc(3*W + W/2);
      check("R7 250 ppm rejects ~3 counts", lock_to_data, 1'b0);
      thr_sel = 2'd3;
      wait_cyc(2*W + W/4);
      check("R7 1000 ppm accepts ~3 counts", lock_to_data, 1'b1);
   endtask

   task automatic t_override();
      do_reset(0, 2'd3, 1'b1);
      wait_cyc(10);
      force_data = 1'b1;
      wait_cyc(1);
      check("R2 force data next edge", lock_to_data, 1'b1);
      check("R9 flag under force", freq_locked, 1'b1);
      force_ref = 1'b1;
      wait_cyc(1);
      check("R2 data wins over ref", lock_to_data, 1'b1);
      force_data = 1'b0;
      wait_cyc(1);
      check("R3 force ref next edge", lock_to_data, 1'b0);
      wait_cyc(3*W);
      check("R3 ref held despite good windows", lock_to_data, 1'b0);
      force_ref = 1'b0; force_data = 1'b1; skip_k = 100;
      wait_cyc(2*W);
      check("R2 data held despite bad windows", lock_to_data, 1'b1);
      force_data = 1'b0;
      wait_cyc(W + W/2);
      check("R8 auto resumes and falls back", lock_to_data, 1'b0);
   endtask

   initial begin
      t_reset();
      t_auto_and_fallback();
      t_phase();
      t_threshold();
      t_override();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule